// File: doc/BRIEF.md
# Sixteen-bit Harvard RISC Core

This block is a single-issue processor core with a 16-bit datapath and 24-bit instruction words. Instruction fetch and data access use two independent ports, so an instruction is fetched and its data access is performed in the same cycle. Every instruction completes in one clock: the program counter drives the instruction port, the fetched word is decoded at once, the operands are read from a sixteen-entry register file, and the result is written back at the next rising edge.

The instruction word has four fields. The opcode sits in bits [23:20], the destination register in [19:16] and the first source register in [15:12]. The low twelve bits hold one of three things, and the opcode decides which. In register mode, [11:8] names the second source register. In immediate mode, the twelve bits are a constant. In direct mode, they are a data address. Multiplication is done by a separate multiplier unit that feeds the ALU. A zero flag records whether the last ALU result was zero, and the branch-if-zero instruction uses it.

The core is a plain fetch-execute loop with no multi-cycle states. A synchronous, active-high reset clears the program counter, the zero flag and every register. Data memory writes take effect at the clock edge. Read data is expected back within the same cycle.

Top module: `risc16_core`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the fetch address is 0. Reset clears all sixteen registers to 0 and clears the zero flag.
- R2: After any instruction other than a taken jump or branch, the fetch address is the previous one plus one. It wraps from 0xFFF to 0x000.
- R3: Opcode encoding is 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 NOT, 7 SHL, 8 SHR, 9 MUL, A ADDI, B ANDI, C LOAD, D STORE, E JMP, F BZ. ADD, SUB, AND, OR and XOR write rd = rs1 op rs2, with rs2 taken from bits [11:8]. SUB computes rs1 minus rs2 modulo 2^16. NOT writes rd = ~rs1.
- R4: SHL and SHR shift rs1 logically by the low four bits of rs2. Upper bits of rs2 are ignored.
- R5: MUL writes the low 16 bits of rs1 times rs2.
- R6: ADDI and ANDI use bits [11:0] as an immediate, zero-extended to 16 bits, in place of rs2.
- R7: LOAD writes the data word at the 12-bit address in bits [11:0] into rd. STORE writes register rs1 (bits [15:12]) to that address. No other opcode writes data memory.
- R8: The eleven ALU opcodes (1 to B) set the zero flag exactly when their result is 0. All other opcodes leave the flag unchanged.
- R9: JMP loads bits [11:0] into the program counter. BZ does the same only when the zero flag is set, and otherwise falls through.
- R10: NOP changes no register, no memory word and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 12 | Instruction fetch address (program counter) |
| imem_data | input | 24 | Instruction word at imem_addr |
| dmem_addr | output | 12 | Data memory address (bits [11:0] of the instruction) |
| dmem_wdata | output | 16 | Data to write on STORE |
| dmem_we | output | 1 | Data memory write enable, taken at the clock edge |
| dmem_rdata | input | 16 | Data word read combinationally at dmem_addr |

## Verification
The bench checks immediates with their top bit set. A sign-extending core would return 0x122F for an ADDI and 0x1200 for an ANDI, where 0x222F and 0x0200 are expected. It runs a BZ after an intervening LOAD and a NOP to confirm the flag survives them. A core that updated the flag on every opcode would skip the taken branch. It shifts by amounts whose upper bits are nonzero, jumps to 0xFFF to confirm the wrap to 0, and checks that ALU immediates which alias data addresses leave memory untouched. A reset run after a program that left nonzero registers and a set flag catches a core that fails to clear its state.

// File: rtl/risc16_pkg.sv
package risc16_pkg;

    localparam int unsigned OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 4'h0,
        OP_ADD   = 4'h1,
        OP_SUB   = 4'h2,
        OP_AND   = 4'h3,
        OP_OR    = 4'h4,
        OP_XOR   = 4'h5,
        OP_NOT   = 4'h6,
        OP_SHL   = 4'h7,
        OP_SHR   = 4'h8,
        OP_MUL   = 4'h9,
        OP_ADDI  = 4'hA,
        OP_ANDI  = 4'hB,
        OP_LOAD  = 4'hC,
        OP_STORE = 4'hD,
        OP_JMP   = 4'hE,
        OP_BZ    = 4'hF
    } opcode_e;

endpackage

// File: rtl/risc16_regfile.sv
module risc16_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int NREG = 1 << REG_AW;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (waddr == REG_AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/risc16_mult.sv
module risc16_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    // shift-and-add chain; only the low W bits of the product are kept
    logic [W-1:0] acc [W+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign acc[i+1] = acc[i] + (b[i] ? (a << i) : '0);
    end

    assign p = acc[W];

endmodule

// File: rtl/risc16_alu.sv
module risc16_alu
    import risc16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] mul_p,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    assign shamt = b[SH_W-1:0];

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDI: y = a + b;
            OP_SUB:          y = a - b;
            OP_AND, OP_ANDI: y = a & b;
            OP_OR:           y = a | b;
            OP_XOR:          y = a ^ b;
            OP_NOT:          y = ~a;
            OP_SHL:          y = a << shamt;
            OP_SHR:          y = a >> shamt;
            OP_MUL:          y = mul_p;
            OP_NOP, OP_LOAD, OP_STORE, OP_JMP, OP_BZ: y = '0;
        endcase
    end

endmodule

// File: rtl/risc16_core.sv
module risc16_core
    import risc16_pkg::*;
#(
    parameter  int DATA_W  = 16,
    parameter  int REG_AW  = 4,
    parameter  int IMM_W   = 12,
    localparam int INSTR_W = OPC_W + 2 * REG_AW + IMM_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IMM_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [IMM_W-1:0]   dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    input  logic [DATA_W-1:0]  dmem_rdata
);
    localparam int RD_HI  = INSTR_W - OPC_W - 1;
    localparam int RS1_HI = RD_HI - REG_AW;

    // decode fields
    opcode_e           opc;
    logic [REG_AW-1:0] f_rd, f_rs1, f_rs2;
    logic [IMM_W-1:0]  f_imm;

    assign opc   = opcode_e'(imem_data[INSTR_W-1 -: OPC_W]);
    assign f_rd  = imem_data[RD_HI -: REG_AW];
    assign f_rs1 = imem_data[RS1_HI -: REG_AW];
    assign f_imm = imem_data[IMM_W-1:0];
    assign f_rs2 = f_imm[IMM_W-1 -: REG_AW];

    // architectural state
    logic [IMM_W-1:0] pc;
    logic             zflag;

    // control
    logic is_alu, use_imm, rf_we, from_mem, st_en, jump_taken;

    always_comb begin
        is_alu     = 1'b0;
        use_imm    = 1'b0;
        rf_we      = 1'b0;
        from_mem   = 1'b0;
        st_en      = 1'b0;
        jump_taken = 1'b0;
        unique case (opc)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT,
            OP_SHL, OP_SHR, OP_MUL: begin
                is_alu = 1'b1;
                rf_we  = 1'b1;
            end
            OP_ADDI, OP_ANDI: begin
                is_alu  = 1'b1;
                rf_we   = 1'b1;
                use_imm = 1'b1;
            end
            OP_LOAD: begin
                rf_we    = 1'b1;
                from_mem = 1'b1;
            end
            OP_STORE: st_en      = 1'b1;
            OP_JMP:   jump_taken = 1'b1;
            OP_BZ:    jump_taken = zflag;
            OP_NOP:   ;
        endcase
    end

    // datapath
    logic [DATA_W-1:0] rs1_val, rs2_val, opnd_b, mul_p, alu_y, wb_val;

    risc16_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we && !rst),
        .waddr   (f_rd),
        .wdata   (wb_val),
        .raddr_a (f_rs1),
        .raddr_b (f_rs2),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val)
    );

    assign opnd_b = use_imm ? {{(DATA_W-IMM_W){1'b0}}, f_imm} : rs2_val;

    risc16_mult #(.W(DATA_W)) u_mul (
        .a (rs1_val),
        .b (opnd_b),
        .p (mul_p)
    );

    risc16_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (opc),
        .a     (rs1_val),
        .b     (opnd_b),
        .mul_p (mul_p),
        .y     (alu_y)
    );

    assign wb_val = from_mem ? dmem_rdata : alu_y;

    // ports
    assign imem_addr  = pc;
    assign dmem_addr  = f_imm;
    assign dmem_wdata = rs1_val;
    assign dmem_we    = st_en && !rst;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            zflag <= 1'b0;
        end else begin
            pc <= jump_taken ? f_imm : pc + IMM_W'(1);
            if (is_alu) begin
                zflag <= (alu_y == '0);
            end
        end
    end

    // checks
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !jump_taken |=> (pc == $past(pc) + IMM_W'(1)));

    a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
        jump_taken |=> (pc == $past(f_imm)));

    a_r7_we_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opc == OP_STORE));

    a_r8_zero_hold: assert property (@(posedge clk) disable iff (rst)
        !is_alu |=> $stable(zflag));

    a_r8_zero_from_alu: assert property (@(posedge clk) disable iff (rst)
        is_alu |=> (zflag == ($past(alu_y) == '0)));

endmodule

// File: tb/tb_risc16_core.sv
module tb_risc16_core;

    localparam logic [3:0] C_NOP = 4'h0, C_ADD = 4'h1, C_SUB = 4'h2, C_AND = 4'h3,
                           C_OR = 4'h4, C_XOR = 4'h5, C_NOT = 4'h6, C_SHL = 4'h7,
                           C_SHR = 4'h8, C_MUL = 4'h9, C_ADDI = 4'hA, C_ANDI = 4'hB,
                           C_LOAD = 4'hC, C_STORE = 4'hD, C_JMP = 4'hE, C_BZ = 4'hF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] imem_addr;
    logic [23:0] imem_data;
    logic [11:0] dmem_addr;
    logic [15:0] dmem_wdata;
    logic        dmem_we;
    logic [15:0] dmem_rdata;

    logic [23:0] imem [256];
    logic [15:0] dmem [256];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign imem_data  = imem[imem_addr[7:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    risc16_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [23:0] enc(logic [3:0] op, logic [3:0] rd,
                                        logic [3:0] rs1, logic [11:0] lo);
        return {op, rd, rs1, lo};
    endfunction

    function automatic logic [23:0] rr(logic [3:0] op, logic [3:0] rd,
                                       logic [3:0] rs1, logic [3:0] rs2);
        return {op, rd, rs1, rs2, 8'h00};
    endfunction

    function automatic logic [23:0] st(logic [3:0] src, logic [11:0] addr);
        return {C_STORE, 4'h0, src, addr};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_mem(logic [15:0] fill);
        for (int i = 0; i < 256; i++) begin
            imem[i] = enc(C_NOP, 4'h0, 4'h0, 12'h000);
            dmem[i] = fill;
        end
    endtask

    task automatic reset_run(int cycles);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    // R3 register-mode ALU operations; leaves the zero flag set for R1 test
    task automatic t_alu_reg();
        logic [15:0] a, b;
        a = 16'h05A3;
        b = 16'h00F0;
        clear_mem(16'h0000);
        imem[0]  = enc(C_ADDI, 4'd1, 4'd0, 12'h5A3);
        imem[1]  = enc(C_ADDI, 4'd2, 4'd0, 12'h0F0);
        imem[2]  = rr(C_ADD, 4'd3, 4'd1, 4'd2);
        imem[3]  = rr(C_SUB, 4'd4, 4'd2, 4'd1);
        imem[4]  = rr(C_AND, 4'd5, 4'd1, 4'd2);
        imem[5]  = rr(C_OR,  4'd6, 4'd1, 4'd2);
        imem[6]  = rr(C_XOR, 4'd7, 4'd1, 4'd2);
        imem[7]  = rr(C_NOT, 4'd8, 4'd1, 4'd0);
        imem[8]  = rr(C_SUB, 4'd9, 4'd1, 4'd1);
        for (int i = 0; i < 7; i++) imem[9+i] = st(4'(3 + i), 12'(16 + i));
        imem[16] = enc(C_JMP, 4'd0, 4'd0, 12'd16);
        reset_run(24);
        check("R3 ADD", dmem[16], a + b);
        check("R3 SUB wrap", dmem[17], b - a);
        check("R3 AND", dmem[18], a & b);
        check("R3 OR", dmem[19], a | b);
        check("R3 XOR", dmem[20], a ^ b);
        check("R3 NOT", dmem[21], ~a);
        check("R3 SUB zero", dmem[22], 16'h0000);
    endtask

    // R4 shifts, R5 multiply, R6 zero-extended immediates
    task automatic t_shift_mul();
        logic [31:0] prod;
        clear_mem(16'h0000);
        imem[0]  = enc(C_ADDI, 4'd1, 4'd0, 12'h123);
        imem[1]  = enc(C_ADDI, 4'd2, 4'd0, 12'h004);
        imem[2]  = enc(C_ADDI, 4'd5, 4'd0, 12'h013);
        imem[3]  = rr(C_SHL, 4'd3, 4'd1, 4'd2);
        imem[4]  = rr(C_SHR, 4'd4, 4'd3, 4'd5);
        imem[5]  = rr(C_MUL, 4'd6, 4'd1, 4'd1);
        imem[6]  = enc(C_ADDI, 4'd7, 4'd3, 12'hFFF);
        imem[7]  = enc(C_ANDI, 4'd8, 4'd3, 12'hF0F);
        imem[8]  = enc(C_ADDI, 4'd9, 4'd0, 12'hFFF);
        imem[9]  = rr(C_MUL, 4'd10, 4'd9, 4'd9);
        imem[10] = rr(C_SHL, 4'd11, 4'd9, 4'd9);
        imem[11] = st(4'd3, 12'd30);
        imem[12] = st(4'd4, 12'd31);
        imem[13] = st(4'd6, 12'd32);
        imem[14] = st(4'd7, 12'd33);
        imem[15] = st(4'd8, 12'd34);
        imem[16] = st(4'd10, 12'd35);
        imem[17] = st(4'd11, 12'd36);
        imem[18] = enc(C_JMP, 4'd0, 4'd0, 12'd18);
        reset_run(26);
        check("R4 SHL", dmem[30], 16'h0123 << 4);
        check("R4 SHR low nibble only", dmem[31], 16'h1230 >> 3);
        prod = 32'h0123 * 32'h0123;
        check("R5 MUL small", dmem[32], prod[15:0]);
        check("R6 ADDI zero-extend", dmem[33], 16'h1230 + 16'h0FFF);
        check("R6 ANDI zero-extend", dmem[34], 16'h1230 & 16'h0F0F);
        prod = 32'h0FFF * 32'h0FFF;
        check("R5 MUL truncate", dmem[35], prod[15:0]);
        check("R4 SHL by 15", dmem[36], 16'h0FFF << 15);
    endtask

    // R7 direct-mode load and store; no stray writes
    task automatic t_load_store();
        clear_mem(16'h5555);
        dmem[40] = 16'hBEEF;
        imem[0] = enc(C_LOAD, 4'd1, 4'd0, 12'd40);
        imem[1] = enc(C_ADDI, 4'd2, 4'd1, 12'd1);
        imem[2] = st(4'd2, 12'd41);
        imem[3] = st(4'd1, 12'd42);
        imem[4] = enc(C_LOAD, 4'd3, 4'd0, 12'd41);
        imem[5] = st(4'd3, 12'd44);
        imem[6] = enc(C_JMP, 4'd0, 4'd0, 12'd6);
        reset_run(12);
        check("R7 store of loaded+1", dmem[41], 16'hBEF0);
        check("R7 store of loaded", dmem[42], 16'hBEEF);
        check("R7 reload", dmem[44], 16'hBEF0);
        check("R7 untouched neighbour", dmem[43], 16'h5555);
        check("R7 ADDI imm not written", dmem[1], 16'h5555);
        check("R7 LOAD addr not written", dmem[40], 16'hBEEF);
        check("R7 JMP target not written", dmem[6], 16'h5555);
    endtask

    // R8 zero flag, R9 jump and branch, R10 NOP
    task automatic t_zero_branch();
        clear_mem(16'h0000);
        dmem[50] = 16'h1234;
        imem[0]  = enc(C_ADDI, 4'd1, 4'd0, 12'd5);
        imem[1]  = rr(C_SUB, 4'd2, 4'd1, 4'd1);
        imem[2]  = enc(C_LOAD, 4'd7, 4'd0, 12'd50);
        imem[3]  = enc(C_NOP, 4'd1, 4'd1, 12'hFFF);
        imem[4]  = enc(C_BZ, 4'd0, 4'd0, 12'd6);
        imem[5]  = enc(C_ADDI, 4'd3, 4'd0, 12'h111);
        imem[6]  = enc(C_ADDI, 4'd4, 4'd0, 12'd1);
        imem[7]  = enc(C_BZ, 4'd0, 4'd0, 12'd9);
        imem[8]  = enc(C_ADDI, 4'd5, 4'd0, 12'h222);
        imem[9]  = enc(C_JMP, 4'd0, 4'd0, 12'd11);
        imem[10] = enc(C_ADDI, 4'd6, 4'd0, 12'h333);
        imem[11] = st(4'd3, 12'd60);
        imem[12] = st(4'd4, 12'd61);
        imem[13] = st(4'd5, 12'd62);
        imem[14] = st(4'd6, 12'd63);
        imem[15] = st(4'd7, 12'd64);
        imem[16] = st(4'd1, 12'd65);
        imem[17] = enc(C_JMP, 4'd0, 4'd0, 12'd17);
        reset_run(24);
        check("R8 flag held over LOAD/NOP, R9 BZ taken", dmem[60], 16'h0000);
        check("R8 ADDI result", dmem[61], 16'h0001);
        check("R9 BZ not taken falls through", dmem[62], 16'h0222);
        check("R9 JMP skips", dmem[63], 16'h0000);
        check("R7 LOAD value", dmem[64], 16'h1234);
        check("R10 NOP leaves rd", dmem[65], 16'h0005);
        check("R10 NOP no write", dmem[255], 16'h0000);
    endtask

    // R1 reset clears registers and zero flag (after t_alu_reg left them set)
    task automatic t_reset();
        clear_mem(16'hFFFF);
        imem[0] = enc(C_BZ, 4'd0, 4'd0, 12'h020);
        for (int i = 0; i < 9; i++) imem[1+i] = st(4'(1 + i), 12'(100 + i));
        imem[10] = enc(C_JMP, 4'd0, 4'd0, 12'd10);
        imem[32] = enc(C_ADDI, 4'd12, 4'd0, 12'hBAD);
        imem[33] = st(4'd12, 12'd110);
        imem[34] = enc(C_JMP, 4'd0, 4'd0, 12'd34);
        reset_run(16);
        for (int i = 0; i < 9; i++) check("R1 register cleared", dmem[100+i], 16'h0000);
        check("R1 zero flag cleared", dmem[110], 16'hFFFF);
    endtask

    // R1 fetch address in reset, R2 increment and wrap
    task automatic t_pc_sequence();
        logic [11:0] exp_seq [6];
        exp_seq = '{12'h000, 12'h001, 12'h002, 12'h003, 12'hFFF, 12'h000};
        clear_mem(16'h0000);
        imem[3] = enc(C_JMP, 4'd0, 4'd0, 12'hFFF);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 fetch address in reset", 16'(imem_addr), 16'h0000);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check("R2 fetch sequence", 16'(imem_addr), 16'(exp_seq[i]));
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_pc_sequence();
        t_alu_reg();
        t_reset();
        t_shift_mul();
        t_load_store();
        t_zero_branch();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule